// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating

This block turns bytes taken from a transmit queue into an asynchronous serial character stream. Each character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop interval. The line rests high between characters. Bit timing comes from a 16x oversampling enable: every bit lasts 16 enable pulses, and the block holds its state on clock cycles where the enable is low. The baud divider and the queue itself sit outside the block.

When hardware flow control is switched on, an active-low clear-to-send input decides whether a new character may begin. From idle, a character starts only while clear-to-send is low. While a character is being sent, clear-to-send is sampled once, half a bit time before the stop interval ends. That sample decides whether the next queued byte follows back-to-back. A character that has begun is always finished. With flow control off, clear-to-send is ignored.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is 1, `shifterEmpty` is 1 and `fifoPop` is 0.
- R2: A character is a 0 start bit followed by the data bits, least significant bit first. Every start, data and parity bit lasts exactly 16 `tick16` pulses, and nothing advances on a cycle where `tick16` is 0.
- R3: `charLen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `fifoData` are not sent.
- R4: With `parityEn`=1, a parity bit follows the data. For `parityOdd`=0 it is the XOR of the sent data bits (even parity); for `parityOdd`=1 it is the inverse (odd parity). With `parityEn`=0 no parity bit is sent.
- R5: The stop interval is high for 16 ticks when `stopLong`=0. When `stopLong`=1 it lasts 32 ticks, or 24 ticks when `charLen`=0.
- R6: `fifoPop` is high for exactly one cycle per character, in the cycle the byte on `fifoData` is taken. If the next character is permitted, it starts with no idle gap: its start bit begins right after the previous stop interval ends.
- R7: With `autoCtsEn`=1 and `ctsN`=1, an idle transmitter starts no character and pops nothing. The cycle after `ctsN` falls, with data queued, the start bit begins.
- R8: With `autoCtsEn`=1, `ctsN` is sampled 8 ticks before the stop interval ends. If it is high there, the current character still completes in full but the next queued byte is held. If it is low there, the next byte follows back-to-back even if `ctsN` rises later in that stop interval.
- R9: With `autoCtsEn`=0, queued bytes are sent whatever the level of `ctsN`.
- R10: `shifterEmpty` is 1 exactly when no character is in progress, and `txd` is 1 whenever `shifterEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| charLen | input | 2 | Data bit count select (0..3 for 5..8 bits) |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stopLong | input | 1 | Long stop interval (2 bits, or 1.5 bits for 5-bit characters) |
| fifoHasData | input | 1 | Transmit queue holds at least one byte |
| fifoData | input | 8 | Byte at the head of the queue |
| autoCtsEn | input | 1 | Enable clear-to-send gating |
| ctsN | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line |
| fifoPop | output | 1 | Queue pop strobe, one cycle per character |
| shifterEmpty | output | 1 | No character in progress |

## Verification
The assertions check, on every cycle, the properties that can be stated locally. These are: a pop only happens with data queued, and never from idle while flow control blocks; no two pops fall on consecutive cycles; the tick counter and the line hold when the enable is low; and an empty shifter always shows a marking line. Only the bench's scenarios can show the exact bit order, the parity value, the bit and stop lengths and the back-to-back starts. The bench sweeps every length, parity and stop combination against a waveform computed arithmetically. The same holds for the effect of clear-to-send at the stop midpoint: a rise just before it holds the next byte, and a rise just after it does not.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  // Strobes from the sequencer to the shifter, one cycle wide
  typedef struct packed {
    logic load;        // capture a byte, drive the start bit
    logic nextData;    // drive the next data bit
    logic emitParity;  // drive the parity bit
    logic emitStop;    // drive marking level for the stop interval
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick16,
  input  logic [1:0] charLen,
  input  logic      parityEn,
  input  logic      stopLong,
  input  logic      fifoHasData,
  input  logic      autoCtsEn,
  input  logic      ctsN,
  output txStrobe_t strb,
  output logic      idle
);

  localparam int CNT_W   = $clog2(2 * OVERSAMPLE);
  localparam int LIM_W   = CNT_W + 1;
  localparam int HALF    = OVERSAMPLE / 2;
  localparam logic [LIM_W-1:0] BIT_LIM   = LIM_W'(OVERSAMPLE);
  localparam logic [LIM_W-1:0] ONEHALF   = LIM_W'(OVERSAMPLE + HALF);
  localparam logic [LIM_W-1:0] DOUBLE    = LIM_W'(2 * OVERSAMPLE);

  txState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic [2:0]       lastIdx;
  logic             useParity;
  logic [LIM_W-1:0] stopLim;
  logic             ctsGrant;

  logic [LIM_W-1:0] curLim;
  logic             bitEnd;
  logic             midStop;
  logic             permit;
  logic             startNow;

  assign curLim  = (state == ST_STOP) ? stopLim : BIT_LIM;
  assign bitEnd  = tick16 && (state != ST_IDLE) &&
                   ({1'b0, tickCnt} == curLim - LIM_W'(1));
  assign midStop = tick16 && (state == ST_STOP) &&
                   ({1'b0, tickCnt} == stopLim - LIM_W'(HALF) - LIM_W'(1));
  assign permit  = !autoCtsEn || ((state == ST_IDLE) ? !ctsN : ctsGrant);
  assign startNow = fifoHasData && permit &&
                    ((state == ST_IDLE) || ((state == ST_STOP) && bitEnd));
  assign idle    = (state == ST_IDLE);

  always_comb begin
    strb = '0;
    strb.load = startNow;
    if (bitEnd) begin
      unique case (state)
        ST_START:  strb.nextData = 1'b1;
        ST_DATA: begin
          if (bitIdx != lastIdx)  strb.nextData   = 1'b1;
          else if (useParity)     strb.emitParity = 1'b1;
          else                    strb.emitStop   = 1'b1;
        end
        ST_PARITY: strb.emitStop = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      lastIdx   <= 3'd7;
      useParity <= 1'b0;
      stopLim   <= BIT_LIM;
      ctsGrant  <= 1'b0;
    end else begin
      if (startNow) begin
        state     <= ST_START;
        tickCnt   <= '0;
        bitIdx    <= '0;
        lastIdx   <= 3'd4 + {1'b0, charLen};
        useParity <= parityEn;
        stopLim   <= !stopLong ? BIT_LIM : ((charLen == 2'd0) ? ONEHALF : DOUBLE);
        ctsGrant  <= 1'b0;
      end else if (bitEnd) begin
        tickCnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            if (bitIdx != lastIdx) bitIdx <= bitIdx + 3'd1;
            else                   state  <= useParity ? ST_PARITY : ST_STOP;
          end
          ST_PARITY: state <= ST_STOP;
          ST_STOP:   state <= ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end else if (tick16 && state != ST_IDLE) begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
      if (midStop) ctsGrant <= !ctsN;
    end
  end

  // R6: a byte is only taken when the queue holds one
  assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> fifoHasData);

  // R6: characters last many cycles, so loads never touch
  assert_single_pop_R6: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> !strb.load);

  // R7: an idle shifter under blocked flow control stays put
  assert_blocked_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (idle && autoCtsEn && ctsN) |-> !strb.load);

  // R2: without an enable pulse the bit timer does not move
  assert_timer_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick16 && !idle && !strb.load) |=> $stable(tickCnt));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] fifoData,
  input  logic [1:0]        charLen,
  input  logic              parityOdd,
  output logic              txd
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] shiftReg;
  logic              parityBit;
  logic [DATA_W-1:0] lenMask;
  logic              parityNext;

  assign lenMask    = ALL_ONES >> (2'd3 - charLen);
  assign parityNext = (^(fifoData & lenMask)) ^ parityOdd;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      txd       <= 1'b1;
    end else begin
      if (strb.load) begin
        shiftReg  <= fifoData;
        parityBit <= parityNext;
        txd       <= 1'b0;
      end else if (strb.nextData) begin
        txd      <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strb.emitParity) begin
        txd <= parityBit;
      end else if (strb.emitStop) begin
        txd <= 1'b1;
      end
    end
  end

  // R2: the line only moves on a strobe from the sequencer
  assert_line_only_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> $stable(txd));

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              stopLong,
  input  logic              fifoHasData,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              autoCtsEn,
  input  logic              ctsN,
  output logic              txd,
  output logic              fifoPop,
  output logic              shifterEmpty
);

  txStrobe_t strb;
  logic      idle;

  uart_tx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rst(rst), .tick16(tick16), .charLen(charLen),
    .parityEn(parityEn), .stopLong(stopLong), .fifoHasData(fifoHasData),
    .autoCtsEn(autoCtsEn), .ctsN(ctsN), .strb(strb), .idle(idle)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .strb(strb), .fifoData(fifoData),
    .charLen(charLen), .parityOdd(parityOdd), .txd(txd)
  );

  assign fifoPop      = strb.load;
  assign shifterEmpty = idle;

  // R10: an empty shifter always leaves the line marking
  assert_empty_marks_R10: assert property (@(posedge clk) disable iff (rst)
    shifterEmpty |-> txd);

  // R9: with gating off, queued data leaves idle at once
  assert_ungated_start_R9: assert property (@(posedge clk) disable iff (rst)
    (shifterEmpty && !autoCtsEn && fifoHasData) |-> fifoPop);

endmodule

// File: tb/tb_uart_tx_flow.sv
module tb_uart_tx_flow;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       stopLong = 1'b0;
  logic       autoCtsEn = 1'b0;
  logic       ctsN = 1'b1;
  logic       txd, fifoPop, shifterEmpty;

  logic [7:0] q [0:7];
  int         head = 0;
  int         tail = 0;
  logic       fifoHasData;
  logic [7:0] fifoData;

  int checks = 0;
  int failures = 0;

  assign fifoHasData = (head != tail);
  assign fifoData    = q[head % 8];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (fifoPop) head <= head + 1;

  uart_tx_flow dut (
    .clk(clk), .rst(rst), .tick16(tick16), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .stopLong(stopLong),
    .fifoHasData(fifoHasData), .fifoData(fifoData), .autoCtsEn(autoCtsEn),
    .ctsN(ctsN), .txd(txd), .fifoPop(fifoPop), .shifterEmpty(shifterEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    q[tail % 8] = b;
    tail++;
  endtask

  function automatic int stopTicks();
    if (!stopLong) return 16;
    return (charLen == 2'd0) ? 24 : 32;
  endfunction

  function automatic logic expLevel(input int k, input logic [7:0] b);
    int n = 5 + int'(charLen);
    int idx = k / 16;
    logic [7:0] m = 8'hFF >> (3 - int'(charLen));
    if (idx == 0) return 1'b0;
    if (idx <= n) return b[idx-1];
    if (parityEn && idx == n + 1) return (^(b & m)) ^ parityOdd;
    return 1'b1;
  endfunction

  // Compare one whole frame, sample k taken after the k-th edge following the load
  task automatic playFrame(input logic [7:0] b, input int ctsAt, input logic ctsVal,
                           output int mism, output int badK);
    int len = 16 * (6 + int'(charLen) + int'(parityEn)) + stopTicks();
    mism = 0;
    badK = -1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (txd !== expLevel(k, b)) begin
        mism++;
        if (badK < 0) badK = k;
      end
      if (k == ctsAt) ctsN = ctsVal;
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int m, bk, cnt;
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && shifterEmpty === 1'b1 && fifoPop === 1'b0,
          "R1 reset state", {txd, shifterEmpty, fifoPop}, 3'b110);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R9: full sweep, gating off with ctsN high
    for (int cfg = 0; cfg < 24; cfg++) begin
      charLen   = 2'(cfg % 4);
      parityEn  = (cfg / 4) % 3 != 0;
      parityOdd = (cfg / 4) % 3 == 2;
      stopLong  = cfg >= 12;
      b0 = 8'(8'hA5 ^ (cfg * 37));
      b1 = 8'(~{b0[2:0], b0[7:3]});
      push(b0);
      push(b1);
      @(posedge clk);
      playFrame(b0, -1, 1'b1, m, bk);
      check(m == 0, "R2 R3 R4 R5 R9 first frame", bk, -1);
      playFrame(b1, -1, 1'b1, m, bk);
      check(m == 0, "R6 back-to-back frame", bk, -1);
      @(negedge clk);
      check(txd === 1'b1 && shifterEmpty === 1'b1 && head == tail,
            "R10 idle after drain", {txd, shifterEmpty}, 2'b11);
    end

    // R7: blocked from idle
    charLen = 2'd3; parityEn = 1'b0; stopLong = 1'b0;
    autoCtsEn = 1'b1; ctsN = 1'b1;
    push(8'h3C);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || shifterEmpty !== 1'b1 || fifoPop !== 1'b0) cnt++;
    end
    check(cnt == 0 && head != tail, "R7 held while ctsN high", cnt, 0);
    ctsN = 1'b0;
    @(posedge clk);
    playFrame(8'h3C, -1, 1'b0, m, bk);
    check(m == 0, "R7 starts after ctsN falls", bk, -1);
    @(negedge clk);

    // R8: ctsN rises before the stop midpoint, next byte held
    push(8'h81);
    push(8'h7E);
    @(posedge clk);
    playFrame(8'h81, 140, 1'b1, m, bk);
    check(m == 0, "R8 current frame completes", bk, -1);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || shifterEmpty !== 1'b1) cnt++;
    end
    check(cnt == 0 && head != tail, "R8 next byte held", cnt, 0);
    ctsN = 1'b0;
    @(posedge clk);
    playFrame(8'h7E, -1, 1'b0, m, bk);
    check(m == 0, "R8 resumes after ctsN falls", bk, -1);
    @(negedge clk);

    // R8: ctsN rises after the stop midpoint, next byte still follows
    push(8'h55);
    push(8'hC3);
    @(posedge clk);
    playFrame(8'h55, 156, 1'b1, m, bk);
    check(m == 0, "R8 frame with late rise", bk, -1);
    playFrame(8'hC3, -1, 1'b1, m, bk);
    check(m == 0, "R8 late rise keeps back-to-back", bk, -1);
    @(negedge clk);
    check(shifterEmpty === 1'b1 && head == tail, "R10 empty after late rise",
          shifterEmpty, 1);

    // R2: enable held low freezes the line mid character
    ctsN = 1'b0;
    push(8'h0F);
    @(posedge clk);
    repeat (20) @(negedge clk);
    tick16 = 1'b0;
    b0[0] = txd;
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (txd !== b0[0]) cnt++;
    end
    check(cnt == 0 && shifterEmpty === 1'b0, "R2 no progress without tick", cnt, 0);
    tick16 = 1'b1;
    repeat (200) @(negedge clk);
    check(shifterEmpty === 1'b1 && txd === 1'b1, "R10 idle after frozen frame",
          {shifterEmpty, txd}, 2'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule